// File: doc/BRIEF.md
# Priority Vector Acknowledge Arbiter

This block resolves which interrupt source a processor is acknowledging when it reads one of two vector/status words. It looks at three 64-bit source vectors (pending, enabled, and fast-class) and a packed array of 4-bit priorities, all of them held in registers outside the block. The *normal* class covers every source that is pending, enabled and not fast-class. Among those, the largest priority wins, and a tie goes to the higher source number. The *fast* class covers sources that are pending, enabled and fast-class, and it always takes the lowest source number. The block returns a 32-bit status word. It also emits a one-cycle clear pulse that names the chosen source, so that the pending store can drop that bit. Reading the word therefore also acknowledges the source.

Each read class has its own request channel with a valid/ready handshake. A request is accepted on a clock edge where its valid and ready are both high. The selection uses the source vectors as they stand at that edge. The response appears on the next cycle and holds until `rsp_ready` takes it. Only one response can be outstanding at a time. While `rsp_valid` is high, both request readies stay low, so the requester sees back-pressure until it has consumed the word. A requester keeps its valid high until the request is accepted. If both classes request at once, fast is accepted first and the normal request waits.

Top module: `vec_ack_arb`

## Requirements
- R1: Out of reset, `rsp_valid` and `clr_pulse` are low and both request readies are high.
- R2: A normal read picks, among sources with pending=1, enable=1 and fast-class=0, the one with the largest priority; among equal priorities the highest source number wins.
- R3: A normal read that finds a source returns a word with the source number in bits 21:16, the priority in bits 3:0, and every other bit zero.
- R4: A fast read picks, among sources with pending=1, enable=1 and fast-class=1, the lowest source number, and returns that number in bits 5:0 with every other bit zero.
- R5: In the cycle after a read that found a source, `clr_pulse` is high for exactly one cycle and `clr_idx` carries the returned source number; `clr_pulse` is never high otherwise.
- R6: A read of either class that has no candidate returns 0xFFFFFFFF and produces no clear pulse.
- R7: A normal candidate with priority 0 is a real candidate and is returned instead of the empty word.
- R8: While `fst_rd_valid` is high, `nrm_rd_ready` is low, so a pair of simultaneous strobes is served fast first and normal afterwards.
- R9: The response word appears one cycle after acceptance and stays valid and unchanged until a cycle with `rsp_ready` high; both readies stay low while it is valid, and input changes made after acceptance do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_vec | input | 64 | Pending bit per source |
| en_vec | input | 64 | Enable bit per source |
| fast_vec | input | 64 | Fast-class bit per source |
| prio_vec | input | 256 | 4-bit priority per source, source i at bits 4i+3:4i |
| nrm_rd_valid | input | 1 | Normal vector read request |
| nrm_rd_ready | output | 1 | Normal request can be accepted |
| fst_rd_valid | input | 1 | Fast vector read request |
| fst_rd_ready | output | 1 | Fast request can be accepted |
| rsp_valid | output | 1 | Status word is valid |
| rsp_ready | input | 1 | Requester takes the status word |
| rsp_word | output | 32 | Status word |
| clr_pulse | output | 1 | One-cycle pending-clear strobe |
| clr_idx | output | 6 | Source whose pending bit is to be cleared |

## Verification
The bench targets several edge cases, and each catches a specific kind of broken design:
- **Priority ties.** Ties are placed at the low and high ends of the index range. A selector that favours the lower index, or compares with a strict inequality, returns the wrong source.
- **Priority zero.** A lone priority-0 candidate is used. A design that treats zero as empty answers 0xFFFFFFFF.
- **Wrong class.** Sources that are pending but disabled, or that belong to the other class, are mixed into the vectors to expose candidate-mask errors.
- **Back-pressure and held words.** The response is held back for several cycles while the input vectors are rewritten. A design that does not latch the word shows the new result instead.
- **Drain sequences.** The bench drains sources read by read, feeding each clear back into the pending vector, and it sends simultaneous strobes. A missing or doubled clear, or a wrong serving order, shows up as an out-of-order source list.

// File: rtl/vack_pkg.sv
package vack_pkg;
  parameter int unsigned VACK_NSRC    = 64;
  parameter int unsigned VACK_PRIO_W  = 4;
  parameter int unsigned VACK_WORD_W  = 32;
  parameter int unsigned VACK_IDX_LSB = 16;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_NRM  = 2'd1,
    KIND_FST  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vack_cand_mask.sv
module vack_cand_mask #(
  parameter int unsigned NSRC = vack_pkg::VACK_NSRC
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] fast,
  output logic [NSRC-1:0] nrm_cand,
  output logic [NSRC-1:0] fst_cand
);
  logic [NSRC-1:0] live;

  assign live = pend & en;

  // Per-source class split; each bit is independent.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign nrm_cand[s] = live[s] & ~fast[s];
    assign fst_cand[s] = live[s] &  fast[s];
  end
endmodule

// File: rtl/vack_pick_tree.sv
// Binary reduction tree over NSRC leaves (NSRC a power of two).
// Heap layout: node n has children 2n+1 (lower indices) and 2n+2.
// PRIO_MODE=1: larger priority wins, ties to the upper (higher index) side.
// PRIO_MODE=0: the lowest-index valid leaf wins.
module vack_pick_tree #(
  parameter int unsigned NSRC      = vack_pkg::VACK_NSRC,
  parameter int unsigned PRIO_W    = vack_pkg::VACK_PRIO_W,
  parameter bit          PRIO_MODE = 1'b1,
  localparam int unsigned IDX_W    = $clog2(NSRC),
  localparam int unsigned NODES    = 2 * NSRC - 1
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output logic [PRIO_W-1:0]      pr
);
  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar i = 0; i < NSRC; i++) begin : g_leaf
    assign nv[NSRC-1+i] = cand[i];
    assign np[NSRC-1+i] = prio[i*PRIO_W +: PRIO_W];
    assign ni[NSRC-1+i] = IDX_W'(i);
  end

  for (genvar n = 0; n < NSRC - 1; n++) begin : g_node
    localparam int unsigned LO = 2 * n + 1;
    localparam int unsigned HI = 2 * n + 2;
    logic take_hi;
    if (PRIO_MODE) begin : g_prio
      assign take_hi = nv[HI] && (!nv[LO] || (np[HI] >= np[LO]));
    end else begin : g_lowest
      assign take_hi = !nv[LO];
    end
    assign nv[n] = nv[LO] | nv[HI];
    assign np[n] = take_hi ? np[HI] : np[LO];
    assign ni[n] = take_hi ? ni[HI] : ni[LO];
  end

  assign found = nv[0];
  assign idx   = ni[0];
  assign pr    = np[0];
endmodule

// File: rtl/vack_rsp_stage.sv
module vack_rsp_stage #(
  parameter int unsigned WORD_W = vack_pkg::VACK_WORD_W,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [WORD_W-1:0] word_in,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              clr_pulse,
  output logic [IDX_W-1:0]  clr_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
      clr_pulse <= 1'b0;
      clr_idx   <= '0;
    end else begin
      clr_pulse <= acc & hit;
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_word  <= word_in;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (acc && hit) begin
        clr_idx <= hit_idx;
      end
    end
  end
endmodule

// File: rtl/vec_ack_arb.sv
module vec_ack_arb #(
  parameter int unsigned NSRC    = vack_pkg::VACK_NSRC,
  parameter int unsigned PRIO_W  = vack_pkg::VACK_PRIO_W,
  parameter int unsigned WORD_W  = vack_pkg::VACK_WORD_W,
  parameter int unsigned IDX_LSB = vack_pkg::VACK_IDX_LSB,
  localparam int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        pend_vec,
  input  logic [NSRC-1:0]        en_vec,
  input  logic [NSRC-1:0]        fast_vec,
  input  logic [NSRC*PRIO_W-1:0] prio_vec,
  input  logic                   nrm_rd_valid,
  output logic                   nrm_rd_ready,
  input  logic                   fst_rd_valid,
  output logic                   fst_rd_ready,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [WORD_W-1:0]      rsp_word,
  output logic                   clr_pulse,
  output logic [IDX_W-1:0]       clr_idx
);
  import vack_pkg::*;

  logic [NSRC-1:0]   nrm_cand, fst_cand;
  logic              n_found, f_found;
  logic [IDX_W-1:0]  n_idx, f_idx;
  logic [PRIO_W-1:0] n_pr, f_pr;

  vack_cand_mask #(.NSRC(NSRC)) u_mask (
    .pend     (pend_vec),
    .en       (en_vec),
    .fast     (fast_vec),
    .nrm_cand (nrm_cand),
    .fst_cand (fst_cand)
  );

  vack_pick_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .PRIO_MODE(1'b1)) u_nrm_tree (
    .cand  (nrm_cand),
    .prio  (prio_vec),
    .found (n_found),
    .idx   (n_idx),
    .pr    (n_pr)
  );

  vack_pick_tree #(.NSRC(NSRC), .PRIO_W(PRIO_W), .PRIO_MODE(1'b0)) u_fst_tree (
    .cand  (fst_cand),
    .prio  (prio_vec),
    .found (f_found),
    .idx   (f_idx),
    .pr    (f_pr)
  );

  // Request side: one outstanding response; fast has precedence.
  ack_kind_e         kind;
  logic              acc;
  logic              win_found;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_pr;
  logic [WORD_W-1:0] word_nxt;

  assign fst_rd_ready = ~rsp_valid;
  assign nrm_rd_ready = ~rsp_valid & ~fst_rd_valid;

  always_comb begin
    if (fst_rd_valid && fst_rd_ready)      kind = KIND_FST;
    else if (nrm_rd_valid && nrm_rd_ready) kind = KIND_NRM;
    else                                   kind = KIND_IDLE;
  end

  assign acc       = (kind != KIND_IDLE);
  assign win_found = (kind == KIND_FST) ? f_found : n_found;
  assign win_idx   = (kind == KIND_FST) ? f_idx   : n_idx;
  assign win_pr    = (kind == KIND_FST) ? f_pr    : n_pr;

  always_comb begin
    word_nxt = '0;
    if (!win_found) begin
      word_nxt = '1;
    end else if (kind == KIND_FST) begin
      word_nxt[IDX_W-1:0] = win_idx;
    end else begin
      word_nxt[IDX_LSB +: IDX_W] = win_idx;
      word_nxt[PRIO_W-1:0]       = win_pr;
    end
  end

  vack_rsp_stage #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .word_in   (word_nxt),
    .hit       (win_found),
    .hit_idx   (win_idx),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word),
    .clr_pulse (clr_pulse),
    .clr_idx   (clr_idx)
  );
endmodule

// File: rtl/vack_chk.sv
module vack_chk #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned IDX_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nrm_rd_ready,
  input logic              fst_rd_valid,
  input logic              fst_rd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_word,
  input logic              clr_pulse,
  input logic [IDX_W-1:0]  clr_idx
);
  // R5
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);

  // R5
  clr_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> $rose(rsp_valid));

  // R5
  clr_idx_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> ((rsp_word[IDX_LSB +: IDX_W] == clr_idx) ||
                   (rsp_word[IDX_W-1:0] == clr_idx)));

  // R6
  empty_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && (rsp_word == '1)) |-> !clr_pulse);

  // R8
  fast_blocks_nrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fst_rd_valid |-> !nrm_rd_ready);

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!nrm_rd_ready && !fst_rd_ready));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word)));
endmodule

bind vec_ack_arb vack_chk #(
  .WORD_W  (WORD_W),
  .IDX_W   (IDX_W),
  .IDX_LSB (IDX_LSB)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .nrm_rd_ready (nrm_rd_ready),
  .fst_rd_valid (fst_rd_valid),
  .fst_rd_ready (fst_rd_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_word     (rsp_word),
  .clr_pulse    (clr_pulse),
  .clr_idx      (clr_idx)
);

// File: tb/vec_ack_arb_tb_top.sv
`timescale 1ns/100ps
module vec_ack_arb_tb_top;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   pend = '0, en = '0, fast = '0;
  logic [255:0]  prio = '0;
  logic          nrm_v = 1'b0, fst_v = 1'b0, rsp_rdy = 1'b0;
  logic          nrm_rdy, fst_rdy, rsp_v, clr_p;
  logic [31:0]   rsp_w;
  logic [5:0]    clr_i;

  int n_vec = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_ack_arb dut_i (
    .clk (clk), .rst_n (rst_n),
    .pend_vec (pend), .en_vec (en), .fast_vec (fast), .prio_vec (prio),
    .nrm_rd_valid (nrm_v), .nrm_rd_ready (nrm_rdy),
    .fst_rd_valid (fst_v), .fst_rd_ready (fst_rdy),
    .rsp_valid (rsp_v), .rsp_ready (rsp_rdy), .rsp_word (rsp_w),
    .clr_pulse (clr_p), .clr_idx (clr_i)
  );

  // ---------------- reference model ----------------
  bit          m_vld = 0, m_clr = 0, m_hit = 0;
  logic [31:0] m_word = '0;
  int          m_idx = 0;
  string       m_tag = "R9";

  function automatic int pick_nrm(output int pr_o);
    int best = -1, sel = -1;
    for (int i = 0; i < NS; i++) begin
      if (pend[i] && en[i] && !fast[i]) begin
        int p = int'(prio[i*4 +: 4]);
        if (p >= best) begin best = p; sel = i; end
      end
    end
    pr_o = best;
    return sel;
  endfunction

  function automatic int pick_fst();
    for (int i = 0; i < NS; i++)
      if (pend[i] && en[i] && fast[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld = 0; m_clr = 0; m_hit = 0;
    end else begin
      m_clr = 0;
      if (m_vld) begin
        if (rsp_rdy) m_vld = 0;
      end else if (fst_v || nrm_v) begin
        int sel, pr;
        if (fst_v) begin
          sel = pick_fst();
          m_word = (sel < 0) ? 32'hFFFF_FFFF : 32'(sel);
          m_tag = (sel < 0) ? "R6" : "R4";
        end else begin
          sel = pick_nrm(pr);
          m_word = (sel < 0) ? 32'hFFFF_FFFF : ((32'(sel) << 16) | 32'(pr));
          m_tag = (sel < 0) ? "R6" : ((pr == 0) ? "R7" : "R2/R3");
        end
        m_vld = 1;
        m_hit = (sel >= 0);
        m_clr = m_hit;
        if (m_hit) m_idx = sel;
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9", "fst_rd_ready", 32'(fst_rdy), 32'(!m_vld));
      chk("R8", "nrm_rd_ready", 32'(nrm_rdy), 32'(!m_vld && !fst_v));
      chk("R9", "rsp_valid", 32'(rsp_v), 32'(m_vld));
      if (m_vld) chk(m_tag, "rsp_word", rsp_w, m_word);
      chk("R5", "clr_pulse", 32'(clr_p), 32'(m_clr));
      if (m_clr) chk("R5", "clr_idx", 32'(clr_i), 32'(m_idx));
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(); @(posedge clk); #1; endtask

  // Consume the outstanding response after 'hold' stalled cycles;
  // feeds the clear back into the pending vector.
  task automatic drain(int hold, bit scramble);
    rsp_rdy = 0;
    step();
    if (m_hit) pend[m_idx] = 1'b0;
    for (int h = 0; h < hold; h++) begin
      if (scramble) begin
        pend = {$urandom, $urandom}; en = {$urandom, $urandom};
        prio = {8{$urandom}};
      end
      step();
    end
    rsp_rdy = 1; step(); rsp_rdy = 0;
  endtask

  task automatic rd(bit f, int hold = 0, bit scramble = 0);
    if (f) fst_v = 1; else nrm_v = 1;
    step();
    fst_v = 0; nrm_v = 0;
    drain(hold, scramble);
  endtask

  task automatic set_prio(int s, int p); prio[s*4 +: 4] = 4'(p); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1: reset state
    chk("R1", "rsp_valid", 32'(rsp_v), 0);
    chk("R1", "clr_pulse", 32'(clr_p), 0);
    chk("R1", "readies", {fst_rdy, nrm_rdy}, 2'b11);
    step();

    // R2: highest priority wins
    en = '1; pend = '0; prio = '0;
    pend[3] = 1; set_prio(3, 5); pend[40] = 1; set_prio(40, 9); pend[12] = 1; set_prio(12, 2);
    rd(0);
    // R2: ties go to the higher index; then drain by priority order (R5 feedback)
    pend = '0; prio = '0;
    pend[0] = 1; set_prio(0, 7); pend[63] = 1; set_prio(63, 7); pend[30] = 1; set_prio(30, 7);
    rd(0); rd(0); rd(0); rd(0);
    // R2: disabled and fast-class sources excluded
    pend = '1; en = '0; fast = '0; prio = {64{4'hF}};
    en[10] = 1; set_prio(10, 1); en[20] = 1; fast[20] = 1;
    rd(0);
    // R7: lone priority-zero candidate
    pend = '0; en = '1; fast = '0; prio = '0; pend[17] = 1;
    rd(0);
    // R4: fast lowest index
    pend = '0; fast = '0; pend[50] = 1; pend[9] = 1; pend[33] = 1;
    fast[50] = 1; fast[33] = 1;
    rd(1); rd(1); rd(1);
    // R6: both classes empty
    pend = '0;
    rd(0); rd(1);
    // R8: simultaneous strobes, fast first then normal
    pend = '0; fast = '0; pend[5] = 1; fast[5] = 1; pend[6] = 1; set_prio(6, 3);
    fst_v = 1; nrm_v = 1;
    step(); fst_v = 0;
    drain(1, 0);
    step(); nrm_v = 0;
    drain(0, 0);
    // R9: back-pressure with inputs rewritten during hold
    pend = '0; pend[44] = 1; set_prio(44, 12);
    rd(0, 4, 1);
    fast = '0; pend = '0; pend[2] = 1; fast[2] = 1;
    rd(1, 3, 1);

    // random mix
    for (int k = 0; k < 400; k++) begin
      pend = {$urandom, $urandom} & {$urandom, $urandom};
      en   = {$urandom, $urandom} | {$urandom, $urandom};
      fast = {$urandom, $urandom} & {$urandom, $urandom};
      prio = {8{$urandom}};
      if (k % 7 == 0) prio = '0;
      if (k % 11 == 0) begin
        fst_v = 1; nrm_v = 1; step(); fst_v = 0;
        drain(k % 3, 0); step(); nrm_v = 0; drain(0, 0);
      end else begin
        rd(bit'($urandom % 2), k % 4, bit'(k % 5 == 0));
      end
    end

    repeat (3) step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule